// File: doc/BRIEF.md
# Voltage and Frequency Operating-Point Sequencer

This block moves a processor core from one operating point to another. An operating point pairs a 5-bit supply-voltage code with a 4-bit clock-frequency step index. Voltage code 0 is the lowest of 32 evenly spaced levels between 1.1 V and 1.6 V. Step index 0 is 200 MHz, and each further step adds 33 MHz. Software posts a target point with a one-cycle request strobe. The sequencer then writes the regulator code and the PLL code in an order that keeps the core safe at every instant. It waits for the regulator's settled pulse and the PLL's lock pulse, and it stalls the core only while the PLL relocks.

The order depends on the direction of the move. When the clock gets faster, the voltage moves first and the clock follows once the supply has settled. When the clock gets slower, or stays at its step, the clock moves first, and the voltage follows after lock. Every target must respect a minimum voltage for its frequency step: 2 × step, capped at 31. A target below that floor is refused. A relock that runs longer than a programmable number of cycles is abandoned and reported.

Top module: `dvfs_seq`

## Requirements
- R1: During and after a synchronous reset, both codes are 0, the sequencer is idle, and `busy`, `cpu_stall`, `done`, `req_err` and `lock_fail` are all low.
- R2: For a target at a higher frequency step whose voltage code differs from the current one, `vreg_code` takes the target first. `pll_code` changes only on the edge that samples `vreg_settled` high, and the two codes never change on the same edge.
- R3: For a target at a lower frequency step, `pll_code` takes the target first and `vreg_code` is left alone. The voltage moves only on the edge that samples `pll_locked` high.
- R4: `cpu_stall` is high exactly while the sequencer waits for lock after writing `pll_code`. It is never high in a cycle in which `vreg_code` has just changed.
- R5: If `pll_locked` is not sampled high within LOCK_TIMEOUT cycles of entering the relock wait, `lock_fail` pulses for one cycle, `cpu_stall` drops and the sequencer goes idle with both codes left as written. A lock in the LOCK_TIMEOUT-th cycle still succeeds.
- R6: A request sampled while the sequencer is busy is held in a single slot, where a newer request replaces an older one. The held request is serviced once the current transition completes.
- R7: A request equal to the current operating point produces a `done` pulse without any change of either code and without raising `busy`.
- R8: A request whose voltage code is below 2 × its frequency step (capped at 31) produces a `req_err` pulse and leaves both codes and `busy` unchanged.
- R9: At all times `vreg_code` is at least the floor of the current `pll_code`.
- R10: At most one of `done`, `req_err` and `lock_fail` is high in any cycle, and `done` pulses one cycle after the final settle or lock that completes a transition.
- R11: A target at the current frequency step changes only the voltage, with no stall. A faster target with the current voltage changes only the frequency, stalling through the relock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | One-cycle strobe posting a target point |
| req_vcode | input | 5 | Target voltage code |
| req_fstep | input | 4 | Target frequency step index |
| vreg_settled | input | 1 | Pulse from the regulator: supply has reached the code |
| pll_locked | input | 1 | Pulse from the PLL: locked at the new rate |
| vreg_code | output | 5 | Code driven to the voltage regulator |
| pll_code | output | 4 | Frequency step driven to the PLL |
| cpu_stall | output | 1 | Core stall, high only during relock |
| busy | output | 1 | A transition is under way |
| done | output | 1 | One-cycle pulse: transition or no-op request complete |
| req_err | output | 1 | One-cycle pulse: request refused for low voltage |
| lock_fail | output | 1 | One-cycle pulse: relock timed out |

## Verification
Two situations are the hardest to reach from the ports. One is a lock pulse that lands in the very last permitted relock cycle rather than one cycle later. The other is a request that overwrites a held one while a transition is running, with a single idle cycle between the end of one transition and the dispatch of the next. The bench drives the settle and lock pulses from its own regulator and PLL model. That model has per-scenario delays and a mode in which the PLL never locks. Setting the lock delay to LOCK_TIMEOUT−1 and then LOCK_TIMEOUT puts the pulse on each side of the limit. Posting two requests back to back during a voltage wait exercises the slot replacement. A reference model compares every output on every cycle.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;

    localparam int VCODE_W    = 5;
    localparam int FSTEP_W    = 4;
    localparam int VMIN_SLOPE = 2;
    localparam int VCODE_MAX  = (1 << VCODE_W) - 1;

    typedef logic [VCODE_W-1:0] vcode_t;
    typedef logic [FSTEP_W-1:0] fstep_t;

    typedef struct packed {
        vcode_t v;
        fstep_t f;
    } opp_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_VFIRST,
        ST_RELOCK,
        ST_VLAST
    } seq_st_t;

    typedef enum logic [2:0] {
        PL_REJECT,
        PL_SAME,
        PL_VOLT_FIRST,
        PL_FREQ_FIRST,
        PL_VOLT_ONLY
    } plan_t;

    // Lowest voltage code that a frequency step may run at.
    function automatic vcode_t vmin_of(input fstep_t f);
        int m;
        m = int'(f) * VMIN_SLOPE;
        if (m > VCODE_MAX) m = VCODE_MAX;
        return vcode_t'(m);
    endfunction

endpackage

// File: rtl/dvfs_req_slot.sv
module dvfs_req_slot
    import dvfs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  opp_t wr_opp,
    input  logic take,
    output logic valid,
    output opp_t opp
);
    // One-deep holding slot; a write outranks a take in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            opp   <= '0;
        end else if (wr_en) begin
            valid <= 1'b1;
            opp   <= wr_opp;
        end else if (take) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/dvfs_plan.sv
module dvfs_plan
    import dvfs_pkg::*;
(
    input  opp_t  tgt,
    input  opp_t  cur,
    output plan_t plan
);
    always_comb begin
        if (tgt.v < vmin_of(tgt.f))      plan = PL_REJECT;
        else if (tgt == cur)             plan = PL_SAME;
        else if (tgt.f > cur.f)          plan = (tgt.v != cur.v) ? PL_VOLT_FIRST : PL_FREQ_FIRST;
        else if (tgt.f < cur.f)          plan = PL_FREQ_FIRST;
        else                             plan = PL_VOLT_ONLY;
    end
endmodule

// File: rtl/dvfs_relock_timer.sv
module dvfs_relock_timer #(
    parameter int LIMIT = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    assign expired = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (!expired) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dvfs_seq.sv
module dvfs_seq
    import dvfs_pkg::*;
#(
    parameter int LOCK_TIMEOUT = 2000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [4:0] req_vcode,
    input  logic [3:0] req_fstep,
    input  logic       vreg_settled,
    input  logic       pll_locked,
    output logic [4:0] vreg_code,
    output logic [3:0] pll_code,
    output logic       cpu_stall,
    output logic       busy,
    output logic       done,
    output logic       req_err,
    output logic       lock_fail
);
    seq_st_t st;
    opp_t    tgt;
    opp_t    slot_opp;
    opp_t    cur_opp;
    logic    slot_valid;
    logic    take;
    logic    relock_expired;
    plan_t   plan;
    logic    done_q, err_q, fail_q;

    assign take    = (st == ST_IDLE) && slot_valid;
    assign cur_opp = '{v: vreg_code, f: pll_code};

    dvfs_req_slot u_slot (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (req_valid),
        .wr_opp ('{v: req_vcode, f: req_fstep}),
        .take   (take),
        .valid  (slot_valid),
        .opp    (slot_opp)
    );

    dvfs_plan u_plan (
        .tgt  (slot_opp),
        .cur  (cur_opp),
        .plan (plan)
    );

    dvfs_relock_timer #(.LIMIT(LOCK_TIMEOUT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (st == ST_RELOCK),
        .expired (relock_expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            tgt       <= '0;
            vreg_code <= '0;
            pll_code  <= '0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
            fail_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            fail_q <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (slot_valid) begin
                        tgt <= slot_opp;
                        unique case (plan)
                            PL_REJECT: err_q  <= 1'b1;
                            PL_SAME:   done_q <= 1'b1;
                            PL_VOLT_FIRST: begin
                                vreg_code <= slot_opp.v;
                                st        <= ST_VFIRST;
                            end
                            PL_FREQ_FIRST: begin
                                pll_code <= slot_opp.f;
                                st       <= ST_RELOCK;
                            end
                            PL_VOLT_ONLY: begin
                                vreg_code <= slot_opp.v;
                                st        <= ST_VLAST;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_VFIRST: begin
                    if (vreg_settled) begin
                        pll_code <= tgt.f;
                        st       <= ST_RELOCK;
                    end
                end
                ST_RELOCK: begin
                    if (pll_locked) begin
                        if (vreg_code != tgt.v) begin
                            vreg_code <= tgt.v;
                            st        <= ST_VLAST;
                        end else begin
                            done_q <= 1'b1;
                            st     <= ST_IDLE;
                        end
                    end else if (relock_expired) begin
                        fail_q <= 1'b1;
                        st     <= ST_IDLE;
                    end
                end
                ST_VLAST: begin
                    if (vreg_settled) begin
                        done_q <= 1'b1;
                        st     <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign cpu_stall = (st == ST_RELOCK);
    assign busy      = (st != ST_IDLE);
    assign done      = done_q;
    assign req_err   = err_q;
    assign lock_fail = fail_q;

endmodule

// File: rtl/dvfs_seq_chk.sv
module dvfs_seq_chk
    import dvfs_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [4:0] vreg_code,
    input logic [3:0] pll_code,
    input logic       cpu_stall,
    input logic       busy,
    input logic       done,
    input logic       req_err,
    input logic       lock_fail
);
    // R2: the two codes never move on the same edge
    p_one_axis_per_edge_r2: assert property (@(posedge clk) disable iff (rst)
        (pll_code != $past(pll_code)) |-> (vreg_code == $past(vreg_code)));

    // R3: a drop in frequency enters the relock wait
    p_down_enters_relock_r3: assert property (@(posedge clk) disable iff (rst)
        (pll_code < $past(pll_code)) |-> cpu_stall);

    // R4: no stall in a cycle where the voltage has just moved
    p_no_stall_on_vmove_r4: assert property (@(posedge clk) disable iff (rst)
        (vreg_code != $past(vreg_code)) |-> !cpu_stall);

    // R4: a stall always implies a transition under way
    p_stall_busy_r4: assert property (@(posedge clk) disable iff (rst)
        cpu_stall |-> busy);

    // R5: a lock failure ends a relock wait
    p_fail_after_stall_r5: assert property (@(posedge clk) disable iff (rst)
        lock_fail |-> ($past(cpu_stall) && !cpu_stall && !busy));

    // R7: a no-op completion leaves both codes alone
    p_same_point_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !$past(busy)) |-> ($stable(vreg_code) && $stable(pll_code)));

    // R8: a refused request changes nothing
    p_reject_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        req_err |-> ($stable(vreg_code) && $stable(pll_code) && !busy));

    // R9: voltage floor for the running frequency
    p_vmin_floor_r9: assert property (@(posedge clk) disable iff (rst)
        vreg_code >= vmin_of(pll_code));

    // R10: status pulses are mutually exclusive
    p_single_event_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, req_err, lock_fail}));

endmodule

bind dvfs_seq dvfs_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .vreg_code (vreg_code),
    .pll_code  (pll_code),
    .cpu_stall (cpu_stall),
    .busy      (busy),
    .done      (done),
    .req_err   (req_err),
    .lock_fail (lock_fail)
);

// File: tb/tb_dvfs_seq.sv
`timescale 1ns/1ps
module tb_dvfs_seq;
    localparam int T = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [4:0] req_vcode = '0;
    logic [3:0] req_fstep = '0;
    logic       vreg_settled = 1'b0;
    logic       pll_locked = 1'b0;
    logic [4:0] vreg_code;
    logic [3:0] pll_code;
    logic       cpu_stall, busy, done, req_err, lock_fail;

    always #10 clk = ~clk;   // 50 MHz

    dvfs_seq #(.LOCK_TIMEOUT(T)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vcode(req_vcode),
        .req_fstep(req_fstep), .vreg_settled(vreg_settled), .pll_locked(pll_locked),
        .vreg_code(vreg_code), .pll_code(pll_code), .cpu_stall(cpu_stall),
        .busy(busy), .done(done), .req_err(req_err), .lock_fail(lock_fail)
    );

    int nvec = 0;
    int nerr = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int floor_v(input int f);
        return (2 * f > 31) ? 31 : 2 * f;
    endfunction

    // ---------------- regulator / PLL environment ----------------
    int  v_dly = 2;
    int  l_dly = 4;
    bit  pll_dead = 0;
    int  seen_v = 0, seen_f = 0;
    int  vcnt = 0, lcnt = 0;
    bit  vact = 0, lact = 0;

    always @(negedge clk) begin
        vreg_settled = 1'b0;
        pll_locked   = 1'b0;
        if (!rst) begin
            if (int'(vreg_code) != seen_v) begin
                seen_v = int'(vreg_code); vcnt = v_dly; vact = 1;
            end
            if (int'(pll_code) != seen_f) begin
                seen_f = int'(pll_code); lcnt = l_dly; lact = !pll_dead;
            end
            if (vact) begin
                if (vcnt == 0) begin vreg_settled = 1'b1; vact = 0; end
                else vcnt--;
            end
            if (lact) begin
                if (lcnt == 0) begin pll_locked = 1'b1; lact = 0; end
                else lcnt--;
            end
        end
    end

    // ---------------- behavioural reference model ----------------
    int m_v = 0, m_f = 0, m_ph = 0, m_tv = 0, m_tf = 0, m_cnt = 0;
    bit m_done = 0, m_err = 0, m_fail = 0;
    int q_v[$];
    int q_f[$];

    always @(posedge clk) begin
        int tv, tf;
        m_done = 0; m_err = 0; m_fail = 0;
        if (rst) begin
            m_v = 0; m_f = 0; m_ph = 0; m_cnt = 0;
            q_v.delete(); q_f.delete();
        end else begin
            case (m_ph)
                0: if (q_v.size() > 0) begin
                    tv = q_v.pop_front(); tf = q_f.pop_front();
                    m_tv = tv; m_tf = tf;
                    if (tv < floor_v(tf)) m_err = 1;
                    else if (tv == m_v && tf == m_f) m_done = 1;
                    else if (tf > m_f) begin
                        if (tv != m_v) begin m_v = tv; m_ph = 1; end
                        else begin m_f = tf; m_ph = 2; m_cnt = 0; end
                    end else if (tf < m_f) begin m_f = tf; m_ph = 2; m_cnt = 0; end
                    else begin m_v = tv; m_ph = 3; end
                end
                1: if (vreg_settled) begin m_f = m_tf; m_ph = 2; m_cnt = 0; end
                2: if (pll_locked) begin
                    if (m_v != m_tv) begin m_v = m_tv; m_ph = 3; end
                    else begin m_done = 1; m_ph = 0; end
                end else if (m_cnt == T - 1) begin m_fail = 1; m_ph = 0; end
                else m_cnt++;
                3: if (vreg_settled) begin m_done = 1; m_ph = 0; end
                default: m_ph = 0;
            endcase
            if (req_valid) begin
                q_v.delete(); q_f.delete();
                q_v.push_back(int'(req_vcode)); q_f.push_back(int'(req_fstep));
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(int'(vreg_code) == m_v, "R2 vreg_code", int'(vreg_code), m_v);
            chk(int'(pll_code) == m_f, "R3 pll_code", int'(pll_code), m_f);
            chk(cpu_stall == (m_ph == 2), "R4 cpu_stall", int'(cpu_stall), int'(m_ph == 2));
            chk(lock_fail == m_fail, "R5 lock_fail", int'(lock_fail), int'(m_fail));
            chk(busy == (m_ph != 0), "R6 busy", int'(busy), int'(m_ph != 0));
            chk(req_err == m_err, "R8 req_err", int'(req_err), int'(m_err));
            chk(done == m_done, "R10 done", int'(done), int'(m_done));
            chk(int'(vreg_code) >= floor_v(int'(pll_code)), "R9 floor",
                int'(vreg_code), floor_v(int'(pll_code)));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic post(input int v, input int f);
        @(negedge clk);
        req_valid = 1'b1; req_vcode = 5'(v); req_fstep = 4'(f);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic settle_idle();
        int quiet = 0;
        while (quiet < 3) begin
            @(negedge clk);
            if (busy) quiet = 0; else quiet++;
        end
    endtask

    task automatic run(input int v, input int f);
        post(v, f);
        settle_idle();
    endtask

    task automatic summary();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        nerr++;
        $display("FAIL R10 watchdog expired actual=1 expected=0");
        summary();
    end

    initial begin
        bit saw_stall, saw_done, saw_err, saw_fail;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(vreg_code == 0 && pll_code == 0, "R1 codes at reset", int'(vreg_code), 0);
        chk(!busy && !cpu_stall && !done && !req_err && !lock_fail, "R1 flags at reset",
            int'({busy, cpu_stall, done, req_err, lock_fail}), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(vreg_code == 0 && pll_code == 0 && !busy, "R1 idle after reset", int'(busy), 0);

        // R2: faster target, voltage first
        run(10, 4);
        chk(vreg_code == 10 && pll_code == 4, "R2 up result", int'(pll_code), 4);

        // R3: slower target, frequency first
        v_dly = 0; l_dly = 1;
        run(4, 1);
        chk(vreg_code == 4 && pll_code == 1, "R3 down result", int'(vreg_code), 4);

        // R11: voltage-only, then frequency-only
        saw_stall = 0;
        post(6, 1);
        repeat (6) @(negedge clk) if (cpu_stall) saw_stall = 1;
        settle_idle();
        chk(!saw_stall && vreg_code == 6, "R11 volt-only no stall", int'(saw_stall), 0);
        saw_stall = 0;
        post(6, 3);
        repeat (6) @(negedge clk) if (cpu_stall) saw_stall = 1;
        settle_idle();
        chk(saw_stall && pll_code == 3 && vreg_code == 6, "R11 freq-only stalls", int'(saw_stall), 1);

        // R7: same point is a quiet no-op
        saw_done = 0;
        post(6, 3);
        repeat (3) @(negedge clk) if (done) saw_done = 1;
        chk(saw_done && vreg_code == 6 && pll_code == 3, "R7 same point done", int'(saw_done), 1);

        // R8: below-floor request rejected (floor for step 5 is 10)
        saw_err = 0;
        post(3, 5);
        repeat (3) @(negedge clk) if (req_err) saw_err = 1;
        chk(saw_err && vreg_code == 6 && pll_code == 3, "R8 reject", int'(saw_err), 1);

        // R6: pending requests while busy, latest wins
        v_dly = 5; l_dly = 3;
        post(20, 8);
        post(12, 6);
        post(14, 7);
        settle_idle();
        chk(vreg_code == 14 && pll_code == 7, "R6 latest pending served", int'(pll_code), 7);

        // R5: PLL never locks
        saw_fail = 0;
        pll_dead = 1;
        post(14, 2);
        repeat (T + 6) @(negedge clk) if (lock_fail) saw_fail = 1;
        settle_idle();
        chk(saw_fail && pll_code == 2 && vreg_code == 14 && !cpu_stall, "R5 timeout abort",
            int'(saw_fail), 1);
        pll_dead = 0;

        // R5: lock in the last permitted cycle succeeds
        saw_fail = 0;
        l_dly = T - 1; v_dly = 1;
        post(12, 6);   // faster step with lower voltage: voltage moves first (R2)
        repeat (T + 8) @(negedge clk) if (lock_fail) saw_fail = 1;
        settle_idle();
        chk(!saw_fail && pll_code == 6 && vreg_code == 12, "R5 lock at limit", int'(saw_fail), 0);

        // R5: one cycle later fails
        saw_fail = 0;
        l_dly = T;
        post(12, 5);
        repeat (T + 6) @(negedge clk) if (lock_fail) saw_fail = 1;
        settle_idle();
        chk(saw_fail && pll_code == 5, "R5 lock past limit", int'(saw_fail), 1);

        // R3 with voltage drop after lock, then R1 reset mid-transition
        l_dly = 2; v_dly = 2;
        run(2, 0);
        chk(vreg_code == 2 && pll_code == 0, "R3 full descent", int'(vreg_code), 2);
        post(30, 15);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(vreg_code == 0 && pll_code == 0 && !busy, "R1 reset mid-transition", int'(vreg_code), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        summary();
    end
endmodule